// File: doc/BRIEF.md
# Staggered Refresh-Window Command Guard

This block sits in a memory controller's command scheduler, beside the unit that works out the earliest legal cycle of a candidate command from the ordinary bank and bus timing rules. The scheduler hands the guard three things: the command kind, the target bank and that earliest cycle. The guard compares the cycle against the refresh schedule it keeps. If the command would still be in progress when the banks must be closed for the coming refresh, the guard moves the command to the cycle at which that refresh has completed. Otherwise the cycle passes through unchanged. The answer is combinational, so it is available in the same cycle as the query.

The guard keeps two cycle numbers for each refresh target: the cycle at which the refresh is due, and a close-by deadline a little earlier by which the banks must be precharged. In whole-rank mode there is one such pair, and the deadline sits tRP before the refresh. In staggered mode every bank has its own pair. The refreshes are spaced one clock apart, and each deadline sits the larger of tRP and the bank count (in clocks) before its refresh. Each time the scheduler reports a refresh, the matching pair moves forward by one refresh interval. A bypass input turns the guard off entirely.

Issuing the refresh commands is the job of another unit. All timings are parameters counted in clock cycles.

Top module: `rfw_guard`

## Requirements
- R1: After reset in whole-rank mode, the refresh is due at cycle T_REFI and the precharge deadline is T_REFI-T_RP.
- R2: After reset in staggered mode, bank b is due at T_REFI-(NUM_BANKS-1)+b. Its deadline is that cycle minus max(NUM_BANKS, T_RP).
- R3: An activate (cmd_kind 0) is moved out when earliest_in + T_RAS is at or past the deadline of its target (the rank, or the bank in staggered mode).
- R4: A read (cmd_kind 1) is moved out when earliest_in + T_RTP is at or past the deadline. A write (cmd_kind 2) is moved out when earliest_in + T_WL + T_BURST + T_WR is at or past it.
- R5: A precharge (cmd_kind 3) is moved out in whole-rank mode when earliest_in is at or past the deadline. In staggered mode a precharge is never moved.
- R6: A command that is moved out gets earliest_out = due cycle + T_RFC, with moved high. Any other command gets earliest_out = earliest_in, with moved low.
- R7: In whole-rank mode, a refresh_evt sampled at a rising edge advances the due cycle and the deadline by T_REFI. The new values take effect from the next cycle.
- R8: In staggered mode, a refresh_evt advances only the pair of bank refresh_bank, by T_REFI. Every other bank keeps its schedule.
- R9: While guard_off is high, earliest_out equals earliest_in, moved is low and refresh_evt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the initial schedule |
| per_bank_mode | input | 1 | Static mode select: 1 staggered per bank, 0 whole rank |
| guard_off | input | 1 | Bypass: pass the cycle through and ignore refresh events |
| cmd_kind | input | 2 | Candidate command: 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BW | Target bank of the candidate |
| earliest_in | input | TW | Earliest cycle from the other timing rules |
| refresh_evt | input | 1 | A refresh has been issued this cycle |
| refresh_bank | input | BW | Bank refreshed (used in staggered mode) |
| earliest_out | output | TW | Earliest cycle after the refresh check |
| moved | output | 1 | The candidate was moved out by the refresh check |

## Verification
The query path has no register, so earliest_out and moved are due in the same cycle as the query. The bench drives each query just after a falling edge and samples it 1 ns later, well clear of the rising edge. A refresh event changes the schedule at the following rising edge. The bench's reference model therefore updates its schedule only after that edge, and queries in the next cycle already see the moved window. Each threshold is probed one cycle on either side, for every command kind in both modes.

// File: rtl/rfw_pkg.sv
`timescale 1ns/1ps
package rfw_pkg;
   typedef enum logic [1:0] {
      RFW_ACT = 2'd0,
      RFW_RD  = 2'd1,
      RFW_WR  = 2'd2,
      RFW_PRE = 2'd3
   } rfw_cmd_e;

   function automatic int unsigned rfw_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rfw_slot.sv
`timescale 1ns/1ps
// One refresh target: due cycle and precharge deadline, stepped by STEP per refresh.
module rfw_slot #(
   parameter int unsigned TW       = 32,
   parameter int unsigned INIT_DUE = 200,
   parameter int unsigned GUARD    = 5,
   parameter int unsigned STEP     = 200
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [TW-1:0] due_q,
   output logic [TW-1:0] limit_q
);
   localparam logic [TW-1:0] DUE0   = TW'(INIT_DUE);
   localparam logic [TW-1:0] LIMIT0 = TW'(INIT_DUE - GUARD);
   localparam logic [TW-1:0] STEPV  = TW'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         due_q   <= DUE0;
         limit_q <= LIMIT0;
      end else if (adv) begin
         due_q   <= due_q + STEPV;
         limit_q <= limit_q + STEPV;
      end
   end
endmodule

// File: rtl/rfw_lead.sv
`timescale 1ns/1ps
// Lead time a command needs before the precharge deadline.
module rfw_lead
   import rfw_pkg::*;
#(
   parameter int unsigned TW      = 32,
   parameter int unsigned T_RAS   = 12,
   parameter int unsigned T_RTP   = 3,
   parameter int unsigned WR_LEAD = 14
) (
   input  rfw_cmd_e      cmd,
   input  logic          per_bank,
   output logic [TW-1:0] lead,
   output logic          applies
);
   always_comb begin
      lead    = '0;
      applies = 1'b1;
      unique case (cmd)
         RFW_ACT: lead = TW'(T_RAS);
         RFW_RD:  lead = TW'(T_RTP);
         RFW_WR:  lead = TW'(WR_LEAD);
         RFW_PRE: applies = !per_bank;
         default: applies = 1'b0;
      endcase
   end
endmodule

// File: rtl/rfw_guard.sv
`timescale 1ns/1ps
module rfw_guard
   import rfw_pkg::*;
#(
   parameter int unsigned TW        = 32,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned T_REFI    = 200,
   parameter int unsigned T_RP      = 5,
   parameter int unsigned T_RAS     = 12,
   parameter int unsigned T_RTP     = 3,
   parameter int unsigned T_WL      = 4,
   parameter int unsigned T_BURST   = 4,
   parameter int unsigned T_WR      = 6,
   parameter int unsigned T_RFC     = 30,
   localparam int unsigned BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          per_bank_mode,
   input  logic          guard_off,
   input  logic [1:0]    cmd_kind,
   input  logic [BW-1:0] cmd_bank,
   input  logic [TW-1:0] earliest_in,
   input  logic          refresh_evt,
   input  logic [BW-1:0] refresh_bank,
   output logic [TW-1:0] earliest_out,
   output logic          moved
);
   localparam int unsigned WR_LEAD  = T_WL + T_BURST + T_WR;
   localparam int unsigned PB_GUARD = rfw_max(NUM_BANKS, T_RP);
   localparam int unsigned PB_FIRST = T_REFI - (NUM_BANKS - 1);

   // elaboration-time parameter checks
   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("rfw_guard: NUM_BANKS must be at least 1");
      end
      if (T_REFI <= NUM_BANKS + PB_GUARD + T_RP + WR_LEAD + T_RAS) begin : g_bad_refi
         $error("rfw_guard: T_REFI too short for the lead times");
      end
      if (TW < 16) begin : g_bad_tw
         $error("rfw_guard: TW too narrow for cycle counts");
      end
   endgenerate

   logic          live_evt;
   logic [TW-1:0] rank_due, rank_lim;
   logic [TW-1:0] bank_due [NUM_BANKS];
   logic [TW-1:0] bank_lim [NUM_BANKS];

   assign live_evt = refresh_evt && !guard_off;

   rfw_slot #(.TW(TW), .INIT_DUE(T_REFI), .GUARD(T_RP), .STEP(T_REFI)) u_rank_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (live_evt && !per_bank_mode),
      .due_q   (rank_due),
      .limit_q (rank_lim)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int unsigned DUE_B = PB_FIRST + b;
         logic hit;
         assign hit = live_evt && per_bank_mode && (refresh_bank == BW'(b));
         rfw_slot #(.TW(TW), .INIT_DUE(DUE_B), .GUARD(PB_GUARD), .STEP(T_REFI)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (hit),
            .due_q   (bank_due[b]),
            .limit_q (bank_lim[b])
         );
      end
   endgenerate

   logic [TW-1:0] lead;
   logic          applies;

   rfw_lead #(.TW(TW), .T_RAS(T_RAS), .T_RTP(T_RTP), .WR_LEAD(WR_LEAD)) u_lead (
      .cmd      (rfw_cmd_e'(cmd_kind)),
      .per_bank (per_bank_mode),
      .lead     (lead),
      .applies  (applies)
   );

   logic [TW-1:0] sel_due, sel_lim;
   logic [TW:0]   reach;
   logic          hit_window;

   always_comb begin
      sel_due = rank_due;
      sel_lim = rank_lim;
      if (per_bank_mode) begin
         sel_due = bank_due[cmd_bank];
         sel_lim = bank_lim[cmd_bank];
      end
   end

   assign reach      = {1'b0, earliest_in} + {1'b0, lead};
   assign hit_window = applies && (reach >= {1'b0, sel_lim});

   always_comb begin
      earliest_out = earliest_in;
      moved        = 1'b0;
      if (!guard_off && hit_window) begin
         earliest_out = sel_due + TW'(T_RFC);
         moved        = 1'b1;
      end
   end
endmodule

// File: rtl/rfw_guard_chk.sv
`timescale 1ns/1ps
module rfw_guard_chk #(
   parameter int unsigned TW     = 32,
   parameter int unsigned BW     = 2,
   parameter int unsigned T_REFI = 200
) (
   input logic          clk,
   input logic          rst_n,
   input logic          per_bank_mode,
   input logic          guard_off,
   input logic [1:0]    cmd_kind,
   input logic [TW-1:0] earliest_in,
   input logic          refresh_evt,
   input logic [TW-1:0] earliest_out,
   input logic          moved,
   input logic [TW-1:0] rank_due,
   input logic [TW-1:0] rank_lim
);
   assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      guard_off |-> (earliest_out == earliest_in) && !moved);

   assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !moved |-> earliest_out == earliest_in);

   assert_pre_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (per_bank_mode && cmd_kind == 2'd3) |-> !moved);

   assert_rank_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_evt && !guard_off && !per_bank_mode) |=>
         (rank_due == $past(rank_due) + TW'(T_REFI)) && (rank_lim == $past(rank_lim) + TW'(T_REFI)));

   assert_rank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_off || per_bank_mode || !refresh_evt) |=> $stable(rank_due) && $stable(rank_lim));
endmodule

bind rfw_guard rfw_guard_chk #(.TW(TW), .BW(BW), .T_REFI(T_REFI)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .per_bank_mode (per_bank_mode),
   .guard_off     (guard_off),
   .cmd_kind      (cmd_kind),
   .earliest_in   (earliest_in),
   .refresh_evt   (refresh_evt),
   .earliest_out  (earliest_out),
   .moved         (moved),
   .rank_due      (rank_due),
   .rank_lim      (rank_lim)
);

// File: tb/rfw_guard_bench.sv
`timescale 1ns/1ps
module rfw_guard_bench;
   localparam int TW = 32, NB = 4, BW = 2;
   localparam int T_REFI = 200, T_RP = 5, T_RAS = 12, T_RTP = 3;
   localparam int T_WL = 4, T_BURST = 4, T_WR = 6, T_RFC = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          per_bank_mode = 1'b0;
   logic          guard_off = 1'b0;
   logic [1:0]    cmd_kind = '0;
   logic [BW-1:0] cmd_bank = '0;
   logic [TW-1:0] earliest_in = '0;
   logic          refresh_evt = 1'b0;
   logic [BW-1:0] refresh_bank = '0;
   logic [TW-1:0] earliest_out;
   logic          moved;

   int checks = 0;
   int errors = 0;

   longint m_due [NB+1];
   longint m_lim [NB+1];

   always #10 clk = ~clk;

   rfw_guard #(.TW(TW), .NUM_BANKS(NB), .T_REFI(T_REFI), .T_RP(T_RP), .T_RAS(T_RAS),
               .T_RTP(T_RTP), .T_WL(T_WL), .T_BURST(T_BURST), .T_WR(T_WR), .T_RFC(T_RFC))
      u_rfw_guard (
      .clk(clk), .rst_n(rst_n), .per_bank_mode(per_bank_mode), .guard_off(guard_off),
      .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .earliest_in(earliest_in),
      .refresh_evt(refresh_evt), .refresh_bank(refresh_bank),
      .earliest_out(earliest_out), .moved(moved));

   // model: index NB is the whole rank
   task automatic model_init();
      int g;
      m_due[NB] = T_REFI;
      m_lim[NB] = T_REFI - T_RP;
      g = (NB > T_RP) ? NB : T_RP;
      for (int b = 0; b < NB; b++) begin
         m_due[b] = T_REFI - (NB - 1) + b;
         m_lim[b] = m_due[b] - g;
      end
   endtask

   task automatic do_reset(input logic pb);
      @(negedge clk);
      rst_n = 1'b0;
      per_bank_mode = pb;
      guard_off = 1'b0;
      refresh_evt = 1'b0;
      repeat (3) @(negedge clk);
      model_init();
      rst_n = 1'b1;
   endtask

   task automatic step(input string req, input int k, input int bank, input longint e,
                       input logic off, input logic ev, input int eb);
      longint lead, exp_o;
      logic   exp_m, applies;
      int     idx;
      @(negedge clk);
      cmd_kind = 2'(k);
      cmd_bank = BW'(bank);
      earliest_in = TW'(e);
      guard_off = off;
      refresh_evt = ev;
      refresh_bank = BW'(eb);
      #1;
      applies = 1'b1;
      case (k)
         0: lead = T_RAS;
         1: lead = T_RTP;
         2: lead = T_WL + T_BURST + T_WR;
         default: begin lead = 0; applies = !per_bank_mode; end
      endcase
      idx = per_bank_mode ? bank : NB;
      exp_m = !off && applies && (e + lead >= m_lim[idx]);
      exp_o = exp_m ? m_due[idx] + T_RFC : e;
      checks++;
      if (earliest_out !== TW'(exp_o) || moved !== exp_m) begin
         errors++;
         $display("FAIL %s: kind=%0d bank=%0d in=%0d out=%0d/moved=%0b expected %0d/%0b",
                  req, k, bank, e, earliest_out, moved, exp_o, exp_m);
      end
      @(posedge clk);
      if (ev && !off) begin
         if (per_bank_mode) begin
            m_due[eb] += T_REFI;
            m_lim[eb] += T_REFI;
         end else begin
            m_due[NB] += T_REFI;
            m_lim[NB] += T_REFI;
         end
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // whole-rank mode
      do_reset(1'b0);
      step("R1", 0, 0, 182, 0, 0, 0);  // ACT just before threshold 183
      step("R1", 0, 0, 183, 0, 0, 0);  // moved to 230
      step("R3", 0, 2, 0, 0, 0, 0);
      step("R4", 1, 0, 191, 0, 0, 0);
      step("R4", 1, 0, 192, 0, 0, 0);
      step("R4", 2, 0, 180, 0, 0, 0);
      step("R4", 2, 0, 181, 0, 0, 0);
      step("R5", 3, 0, 194, 0, 0, 0);
      step("R5", 3, 0, 195, 0, 0, 0);
      step("R6", 0, 0, 5000, 0, 0, 0);
      step("R9", 0, 0, 300, 1, 1, 0);  // bypass, event ignored
      step("R9", 0, 0, 183, 0, 0, 0);  // schedule unchanged: still moved to 230
      for (int k = 0; k < 4; k++)
         for (int e = 175; e < 200; e++)
            step("R3", k, 1, e, 0, 0, 0);
      step("R7", 1, 0, 0, 0, 1, 0);    // refresh event
      step("R7", 0, 0, 382, 0, 0, 0);
      step("R7", 0, 0, 383, 0, 0, 0);  // moved to 430
      step("R7", 3, 0, 395, 0, 0, 0);

      // staggered mode
      do_reset(1'b1);
      step("R2", 0, 0, 179, 0, 0, 0);
      step("R2", 0, 0, 180, 0, 0, 0);  // moved to 227
      step("R2", 0, 3, 182, 0, 0, 0);
      step("R2", 0, 3, 183, 0, 0, 0);  // moved to 230
      step("R5", 3, 2, 1000, 0, 0, 0); // precharge never moved
      for (int b = 0; b < NB; b++)
         for (int k = 0; k < 4; k++)
            for (int e = 172; e < 196; e++)
               step("R4", k, b, e, 0, 0, 0);
      step("R8", 0, 0, 0, 0, 1, 1);    // refresh bank 1
      step("R8", 0, 1, 381, 0, 0, 0);  // moved to 428
      step("R8", 0, 1, 380, 0, 0, 0);
      step("R8", 0, 2, 182, 0, 0, 0);  // bank 2 unchanged, moved to 229
      step("R8", 0, 0, 180, 0, 0, 0);  // bank 0 unchanged
      step("R9", 0, 2, 0, 1, 1, 2);    // ignored event
      step("R9", 0, 2, 182, 0, 0, 0);  // still 229

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule